// File: doc/BRIEF.md
# Register-Operand Integer Execute Unit

This block is the execute stage of a 32-bit load/store processor. Each cycle it takes one decoded operation, the values of two source registers, a 5-bit literal shift count and a 16-bit immediate. In the same cycle it returns a 32-bit result and a write strobe for the register file. A second output tells the register file which register to write: the named destination, or the first source register. Increment, decrement and the two shifts write back in place, so they select the first source register.

The only state is a set of three status flags: equal, greater-than and less-than. Only a compare changes them, and the change is visible one clock after the compare is issued. Every other operation, and every idle cycle, leaves them unchanged. Instruction fetch, binary decode, the register array and memory lie outside the block. For the upper-immediate load, the caller presents the destination's current value on the first source operand.

Top module: `regop_exec`

## Requirements
- R1: During and right after reset, all three flags read 0. While `opValid` is 0, `wrEn` is 0.
- R2: Code 1 (move) returns `srcA` unchanged. Code 2 (sign-extending move) returns `srcA[7:0]` with bit 7 copied into bits 31:8. Both assert `wrEn` with `wrToSrc`=0.
- R3: Code 3 returns `srcA+srcB` and code 4 returns `srcA-srcB`, both modulo 2^32. `wrToSrc`=0.
- R4: Code 5 returns `srcA+1` and code 6 returns `srcA-1`, both modulo 2^32. Both assert `wrEn` and `wrToSrc`=1.
- R5: Codes 7 to 13 return AND, OR, NOT of `srcA` alone, XOR, NAND, NOR and XNOR of `srcA` and `srcB`, in that code order. `wrToSrc`=0.
- R6: Code 14 shifts `srcA` left and code 15 shifts it right, both logically. The count is `srcB[4:0]` when `srcB` is non-zero; only when `srcB` equals 0 is it `shLit`. Both write with `wrToSrc`=1.
- R7: Code 16 returns `imm` zero-extended, so bits 31:16 are 0. `wrToSrc`=0.
- R8: Code 17 returns `imm` in bits 31:16 and `srcA[15:0]` in bits 15:0. `wrToSrc`=0.
- R9: Code 18 (compare) keeps `wrEn` at 0. One cycle later the flags show an unsigned comparison of `srcA` with `srcB`, with exactly one of `flagEq`, `flagGt` (`srcA>srcB`) and `flagLt` set.
- R10: The flags keep their value through every cycle that is not a valid compare.
- R11: Codes 0 and 19 to 31 write nothing and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 5 | Decoded operation code |
| srcA | input | 32 | First source operand |
| srcB | input | 32 | Second source operand |
| shLit | input | 5 | Literal shift count |
| imm | input | 16 | Immediate value |
| result | output | 32 | Write-back value |
| wrEn | output | 1 | Register write strobe |
| wrToSrc | output | 1 | 1: write to first source register, 0: to destination |
| flagEq | output | 1 | Last compare found operands equal |
| flagGt | output | 1 | Last compare found srcA greater (unsigned) |
| flagLt | output | 1 | Last compare found srcA less (unsigned) |

## Verification
Two functions can fall in the same cycle. In one, the flags registered by a compare are still on display while the next operation, possibly another compare, is being evaluated. The bench issues back-to-back compares with different outcomes. It also places shifts and logic operations directly after a compare, and checks one cycle after each issue that the flags match the most recent compare only. In the other, a shift presents both a register count and a literal count at once. Here the bench judges which count was used, including a non-zero register whose low five bits are zero and which must therefore give a shift of zero.

// File: rtl/regop_pkg.sv
package regop_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NOP  = 5'd0,  OP_MOV  = 5'd1,  OP_MOVS = 5'd2,  OP_ADD  = 5'd3,
    OP_SUB  = 5'd4,  OP_INC  = 5'd5,  OP_DEC  = 5'd6,  OP_AND  = 5'd7,
    OP_OR   = 5'd8,  OP_NOT  = 5'd9,  OP_XOR  = 5'd10, OP_NAND = 5'd11,
    OP_NOR  = 5'd12, OP_XNOR = 5'd13, OP_SHL  = 5'd14, OP_SHR  = 5'd15,
    OP_LLI  = 5'd16, OP_LUI  = 5'd17, OP_CMP  = 5'd18
  } opcode_e;

  typedef enum logic [3:0] {
    SEL_PASS, SEL_SEXT, SEL_ADD, SEL_SUB, SEL_AND, SEL_OR, SEL_NOT,
    SEL_XOR, SEL_NAND, SEL_NOR, SEL_XNOR, SEL_SHL, SEL_SHR, SEL_LLI, SEL_LUI
  } ressel_e;

  typedef struct packed {
    logic    wrReg;
    logic    toSrc;
    logic    cmpUpd;
    logic    useOne;
    ressel_e sel;
  } strobe_t;
endpackage

// File: rtl/regop_ctrl.sv
module regop_ctrl
  import regop_pkg::*;
(
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  output strobe_t         stb
);
  always_comb begin
    stb = '{wrReg: 1'b0, toSrc: 1'b0, cmpUpd: 1'b0, useOne: 1'b0, sel: SEL_PASS};
    if (opValid) begin
      unique case (opCode)
        OP_MOV:  begin stb.wrReg = 1'b1; stb.sel = SEL_PASS; end
        OP_MOVS: begin stb.wrReg = 1'b1; stb.sel = SEL_SEXT; end
        OP_ADD:  begin stb.wrReg = 1'b1; stb.sel = SEL_ADD;  end
        OP_SUB:  begin stb.wrReg = 1'b1; stb.sel = SEL_SUB;  end
        OP_INC:  begin stb.wrReg = 1'b1; stb.toSrc = 1'b1; stb.useOne = 1'b1; stb.sel = SEL_ADD; end
        OP_DEC:  begin stb.wrReg = 1'b1; stb.toSrc = 1'b1; stb.useOne = 1'b1; stb.sel = SEL_SUB; end
        OP_AND:  begin stb.wrReg = 1'b1; stb.sel = SEL_AND;  end
        OP_OR:   begin stb.wrReg = 1'b1; stb.sel = SEL_OR;   end
        OP_NOT:  begin stb.wrReg = 1'b1; stb.sel = SEL_NOT;  end
        OP_XOR:  begin stb.wrReg = 1'b1; stb.sel = SEL_XOR;  end
        OP_NAND: begin stb.wrReg = 1'b1; stb.sel = SEL_NAND; end
        OP_NOR:  begin stb.wrReg = 1'b1; stb.sel = SEL_NOR;  end
        OP_XNOR: begin stb.wrReg = 1'b1; stb.sel = SEL_XNOR; end
        OP_SHL:  begin stb.wrReg = 1'b1; stb.toSrc = 1'b1; stb.sel = SEL_SHL; end
        OP_SHR:  begin stb.wrReg = 1'b1; stb.toSrc = 1'b1; stb.sel = SEL_SHR; end
        OP_LLI:  begin stb.wrReg = 1'b1; stb.sel = SEL_LLI;  end
        OP_LUI:  begin stb.wrReg = 1'b1; stb.sel = SEL_LUI;  end
        OP_CMP:  stb.cmpUpd = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/regop_dpath.sv
module regop_dpath
  import regop_pkg::*;
#(
  parameter int DataW = 32,
  parameter int ImmW  = 16,
  parameter int ShW   = $clog2(DataW)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          stb,
  input  logic [DataW-1:0] srcA,
  input  logic [DataW-1:0] srcB,
  input  logic [ShW-1:0]   shLit,
  input  logic [ImmW-1:0]  imm,
  output logic [DataW-1:0] result,
  output logic             flagEq,
  output logic             flagGt,
  output logic             flagLt
);
  localparam int ByteW = 8;
  localparam int LowW  = DataW - ImmW;

  logic [DataW-1:0] opB;
  logic [ShW-1:0]   shAmt;

  assign opB   = stb.useOne ? DataW'(1) : srcB;
  assign shAmt = (srcB != '0) ? srcB[ShW-1:0] : shLit;

  always_comb begin
    unique case (stb.sel)
      SEL_PASS: result = srcA;
      SEL_SEXT: result = {{(DataW-ByteW){srcA[ByteW-1]}}, srcA[ByteW-1:0]};
      SEL_ADD:  result = srcA + opB;
      SEL_SUB:  result = srcA - opB;
      SEL_AND:  result = srcA & srcB;
      SEL_OR:   result = srcA | srcB;
      SEL_NOT:  result = ~srcA;
      SEL_XOR:  result = srcA ^ srcB;
      SEL_NAND: result = ~(srcA & srcB);
      SEL_NOR:  result = ~(srcA | srcB);
      SEL_XNOR: result = ~(srcA ^ srcB);
      SEL_SHL:  result = srcA << shAmt;
      SEL_SHR:  result = srcA >> shAmt;
      SEL_LLI:  result = {{LowW{1'b0}}, imm};
      SEL_LUI:  result = {imm, srcA[LowW-1:0]};
      default:  result = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagEq <= 1'b0;
      flagGt <= 1'b0;
      flagLt <= 1'b0;
    end else if (stb.cmpUpd) begin
      flagEq <= (srcA == srcB);
      flagGt <= (srcA > srcB);
      flagLt <= (srcA < srcB);
    end
  end

  a_r9_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    stb.cmpUpd |=> $countones({flagEq, flagGt, flagLt}) == 1);
  a_r10_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.cmpUpd |=> $stable({flagEq, flagGt, flagLt}));
  a_r7_lli_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.sel == SEL_LLI) |-> (result[DataW-1:ImmW] == '0));
  a_r8_lui_low_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.sel == SEL_LUI) |-> (result[LowW-1:0] == srcA[LowW-1:0]));
endmodule

// File: rtl/regop_exec.sv
module regop_exec
  import regop_pkg::*;
#(
  parameter int DataW = 32,
  parameter int ImmW  = 16,
  parameter int ShW   = $clog2(DataW)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             opValid,
  input  logic [OP_W-1:0]  opCode,
  input  logic [DataW-1:0] srcA,
  input  logic [DataW-1:0] srcB,
  input  logic [ShW-1:0]   shLit,
  input  logic [ImmW-1:0]  imm,
  output logic [DataW-1:0] result,
  output logic             wrEn,
  output logic             wrToSrc,
  output logic             flagEq,
  output logic             flagGt,
  output logic             flagLt
);
  strobe_t stb;

  regop_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .stb     (stb)
  );

  regop_dpath #(.DataW(DataW), .ImmW(ImmW), .ShW(ShW)) u_dpath (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb    (stb),
    .srcA   (srcA),
    .srcB   (srcB),
    .shLit  (shLit),
    .imm    (imm),
    .result (result),
    .flagEq (flagEq),
    .flagGt (flagGt),
    .flagLt (flagLt)
  );

  assign wrEn    = stb.wrReg;
  assign wrToSrc = stb.toSrc;

  a_r1_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !opValid |-> !wrEn);
  a_r9_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && opCode == OP_CMP) |-> !wrEn);
  a_r11_undefined_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (opValid && (opCode == OP_NOP || opCode > OP_CMP)) |=> ($stable({flagEq, flagGt, flagLt}) && $past(!wrEn)));
endmodule

// File: tb/tb_regop_exec.sv
module tb_regop_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        opValid = 1'b0;
  logic [4:0]  opCode = '0;
  logic [31:0] srcA = '0, srcB = '0;
  logic [4:0]  shLit = '0;
  logic [15:0] imm = '0;
  logic [31:0] result;
  logic        wrEn, wrToSrc, flagEq, flagGt, flagLt;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  regop_exec dut (
    .clk(clk), .rst_n(rst_n), .opValid(opValid), .opCode(opCode),
    .srcA(srcA), .srcB(srcB), .shLit(shLit), .imm(imm),
    .result(result), .wrEn(wrEn), .wrToSrc(wrToSrc),
    .flagEq(flagEq), .flagGt(flagGt), .flagLt(flagLt)
  );

  // scoreboard queues
  logic [31:0] qRes[$];
  logic        qWr[$];
  logic        qToSrc[$];
  logic [2:0]  qFlags[$];
  string       qTag[$];

  logic [2:0] modelFlags = 3'b000;  // {eq, gt, lt}

  task automatic issue(input string tag, input logic v, input logic [4:0] code,
                       input logic [31:0] a, input logic [31:0] b,
                       input logic [4:0] lit, input logic [15:0] im);
    logic [31:0] r;
    logic        w, ts;
    logic [4:0]  amt;
    r = '0; w = 1'b0; ts = 1'b0;
    amt = (b != 0) ? b[4:0] : lit;
    if (v) begin
      case (code)
        5'd1:  begin r = a; w = 1; end
        5'd2:  begin r = {{24{a[7]}}, a[7:0]}; w = 1; end
        5'd3:  begin r = a + b; w = 1; end
        5'd4:  begin r = a - b; w = 1; end
        5'd5:  begin r = a + 32'd1; w = 1; ts = 1; end
        5'd6:  begin r = a - 32'd1; w = 1; ts = 1; end
        5'd7:  begin r = a & b; w = 1; end
        5'd8:  begin r = a | b; w = 1; end
        5'd9:  begin r = ~a; w = 1; end
        5'd10: begin r = a ^ b; w = 1; end
        5'd11: begin r = ~(a & b); w = 1; end
        5'd12: begin r = ~(a | b); w = 1; end
        5'd13: begin r = ~(a ^ b); w = 1; end
        5'd14: begin r = a << amt; w = 1; ts = 1; end
        5'd15: begin r = a >> amt; w = 1; ts = 1; end
        5'd16: begin r = {16'h0, im}; w = 1; end
        5'd17: begin r = {im, a[15:0]}; w = 1; end
        5'd18: modelFlags = {a == b, a > b, a < b};
        default: ;
      endcase
    end
    @(negedge clk);
    opValid = v; opCode = code; srcA = a; srcB = b; shLit = lit; imm = im;
    qRes.push_back(r); qWr.push_back(w); qToSrc.push_back(ts);
    qFlags.push_back(modelFlags); qTag.push_back(tag);
  endtask

  // monitor: comb outputs of the op and the flags it leaves are both visible after the edge
  always @(posedge clk) begin
    #1;
    if (!finished && qTag.size() > 0) begin
      logic [31:0] eR; logic eW, eT; logic [2:0] eF; string t;
      eR = qRes.pop_front(); eW = qWr.pop_front(); eT = qToSrc.pop_front();
      eF = qFlags.pop_front(); t = qTag.pop_front();
      total++;
      if (wrEn !== eW || (eW && (result !== eR || wrToSrc !== eT)) ||
          {flagEq, flagGt, flagLt} !== eF) begin
        bad++;
        $display("FAIL %s: got res=%h wr=%b toSrc=%b flags=%b exp res=%h wr=%b toSrc=%b flags=%b",
                 t, result, wrEn, wrToSrc, {flagEq, flagGt, flagLt}, eR, eW, eT, eF);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    total++;  // R1 flags and write strobe in reset
    if ({flagEq, flagGt, flagLt} !== 3'b000 || wrEn !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: got flags=%b wr=%b exp flags=000 wr=0", {flagEq, flagGt, flagLt}, wrEn);
    end
    @(negedge clk); rst_n = 1'b1;
    issue("R1 idle", 0, 5'd3, 32'h1, 32'h2, 0, 0);
    issue("R2 mov", 1, 5'd1, 32'hDEADBEEF, 0, 0, 0);
    issue("R2 movs neg", 1, 5'd2, 32'h1234_5680, 0, 0, 0);
    issue("R2 movs pos", 1, 5'd2, 32'hFFFF_FF7F, 0, 0, 0);
    issue("R3 add wrap", 1, 5'd3, 32'hFFFF_FFFF, 32'd2, 0, 0);
    issue("R3 sub wrap", 1, 5'd4, 32'd0, 32'd1, 0, 0);
    issue("R4 inc wrap", 1, 5'd5, 32'hFFFF_FFFF, 32'h55, 0, 0);
    issue("R4 dec wrap", 1, 5'd6, 32'd0, 32'h55, 0, 0);
    for (int c = 7; c <= 13; c++)
      issue("R5 logic", 1, 5'(c), 32'hF0F0_3C3C, 32'hFF00_5A5A, 0, 0);
    issue("R9 cmp gt unsigned", 1, 5'd18, 32'h8000_0000, 32'd1, 0, 0);
    issue("R6 shl literal", 1, 5'd14, 32'h0000_00F1, 32'd0, 5'd4, 0);
    issue("R9 cmp lt", 1, 5'd18, 32'd5, 32'd9, 0, 0);
    issue("R9 cmp eq back-to-back", 1, 5'd18, 32'hABCD, 32'hABCD, 0, 0);
    issue("R6 shl register", 1, 5'd14, 32'h0000_00F1, 32'd3, 5'd7, 0);
    issue("R6 shr reg low bits zero", 1, 5'd15, 32'h8000_0001, 32'd32, 5'd9, 0);
    issue("R6 shr reg 33", 1, 5'd15, 32'h8000_0001, 32'h21, 5'd9, 0);
    issue("R6 shr literal 31", 1, 5'd15, 32'h8000_0001, 32'd0, 5'd31, 0);
    issue("R7 lli", 1, 5'd16, 32'hFFFF_FFFF, 0, 0, 16'hBEEF);
    issue("R8 lui", 1, 5'd17, 32'h1111_2222, 0, 0, 16'hCAFE);
    issue("R10 idle cmp ignored", 0, 5'd18, 32'd1, 32'd7, 0, 0);
    issue("R11 code 0", 1, 5'd0, 32'd9, 32'd1, 0, 0);
    issue("R11 code 25", 1, 5'd25, 32'd9, 32'd1, 0, 0);
    issue("R11 code 31", 1, 5'd31, 32'd0, 32'd1, 0, 0);
    issue("R9 cmp gt", 1, 5'd18, 32'd10, 32'd3, 0, 0);
    issue("R10 hold after add", 1, 5'd3, 32'd1, 32'd1, 0, 0);
    @(negedge clk); opValid = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule